// File: doc/BRIEF.md
# Two-Dimensional DMA Element Sequencer

This block is the transfer engine of a single DMA channel. Once started, it moves data one element at a time. The elements form frames, and a fixed number of frames forms a block. For every element the engine issues a read at the source address, waits for the data, and then issues a write at the destination address. After each element, each address moves by its own signed element stride. When a frame completes, each address also takes its own signed frame stride.

Two data modes replace the plain copy. In fill mode no read is made and the colour value is written. In colour-key copy mode a write is dropped when the data matches the colour value. The engine emits one-cycle event pulses at half-frame, first-element-of-last-frame, frame, packet and block boundaries. It also signals when the channel must pause, stop, reload its working set or start a linked channel. A single `go` strobe starts the channel from idle and resumes it after a pause.

Top module: `dma2d_seq`

## Requirements
- R1: After each element, the source and destination addresses each add their own sign-extended 16-bit element stride. On the element that ends a frame, they also add their own signed 32-bit frame stride. The first element of a block uses the base addresses. Each write carries the data returned by the read of the same element.
- R2: With `cfg_fill` set, no read is issued. The write data is `cfg_color` masked to the element size: code 0 is 1 byte, code 1 is 2 bytes, code 2 is 4 bytes (low bits kept).
- R3: With `cfg_tcopy` set, the write of an element is suppressed when its masked read data equals the masked `cfg_color`. Addresses still advance.
- R4: When a frame ends and `cfg_sync` is clear, `cur_pos` takes the low 16 bits of the destination address for the next element. On a synchronised channel `cur_pos` is left unchanged.
- R5: `ev` pulses for one cycle after an element completes. The bit positions are: bit 0 half-frame (element index within the frame reaches floor(n_elem/2), never when that value is 0); bit 1 last-frame (first element of the final frame); bit 2 frame end; bit 3 end of packet; bit 4 end of block. Each bit is ANDed with the same bit of `cfg_ien`.
- R6: With `cfg_fsync` and `cfg_bsync` both set, a packet counter of `cfg_n_pkt` elements runs across frame boundaries. At each packet end, `ev[3]` fires unless `cfg_src_sync` is set. `deact` fires if `cfg_sync` is set.
- R7: A synchronised channel with both sync bits clear pauses (`deact`) after every element. With `cfg_fsync` set and `cfg_bsync` clear, it pauses after every frame. `go` resumes the channel where it stopped.
- R8: With `cfg_legacy` set, end of block pulses `ch_disable`, and also `link_req` when `cfg_link_en` is set.
- R9: With `cfg_legacy` clear, end of block works as follows. If `cfg_auto_init` is clear, `ch_disable` pulses. If `cfg_repeat` or `cfg_end_prog` is set, `reload` pulses and the next element restarts from the base addresses. Otherwise `wait_prog` is set and `deact` pulses, and the next `go` reloads and clears `wait_prog`. `deact` and `ch_disable` never pulse together.
- R10: After reset no request, event or control pulse is active, and `cur_pos` and `wait_prog` are zero.
- R11: At most one of `rd_req` and `wr_req` is high at a time. Each non-fill element makes exactly one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start from idle, resume from pause |
| cfg_src_base | input | AW | Source base address |
| cfg_dst_base | input | AW | Destination base address |
| cfg_src_eidx | input | 16 | Signed source element stride |
| cfg_dst_eidx | input | 16 | Signed destination element stride |
| cfg_src_fidx | input | 32 | Signed source frame stride |
| cfg_dst_fidx | input | 32 | Signed destination frame stride |
| cfg_n_elem | input | 24 | Elements per frame (at least 1) |
| cfg_n_frame | input | 16 | Frames per block (at least 1) |
| cfg_n_pkt | input | 24 | Elements per packet (at least 1) |
| cfg_size | input | 2 | Element size code |
| cfg_color | input | 32 | Fill / key colour |
| cfg_fill | input | 1 | Constant fill mode |
| cfg_tcopy | input | 1 | Colour-key copy mode |
| cfg_sync | input | 1 | Channel is request-synchronised |
| cfg_fsync | input | 1 | Frame-sync bit |
| cfg_bsync | input | 1 | Block-sync bit |
| cfg_src_sync | input | 1 | Request comes from the source side |
| cfg_legacy | input | 1 | Legacy end-of-block behaviour |
| cfg_link_en | input | 1 | Start linked channel at end of block |
| cfg_auto_init | input | 1 | Auto-initialise at end of block |
| cfg_repeat | input | 1 | Repeat block |
| cfg_end_prog | input | 1 | Reprogramming finished |
| cfg_ien | input | 5 | Event enables |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| rd_req | output | 1 | Read request |
| rd_addr | output | AW | Read address |
| wr_req | output | 1 | Write request |
| wr_addr | output | AW | Write address |
| wr_data | output | 32 | Write data |
| ev | output | 5 | Event pulses |
| deact | output | 1 | Channel pauses |
| ch_disable | output | 1 | Channel disabled |
| reload | output | 1 | Working set reloaded |
| link_req | output | 1 | Enable linked channel |
| wait_prog | output | 1 | Waiting for reprogramming |
| cur_pos | output | 16 | Destination position at last frame end |

## Verification
A wrong element or frame counter appears at the ports within one element. The address on the next read or write no longer follows the stride sum, and the frame stride is either missing or applied at the wrong point. A stale address register appears on the very next request. A wrong packet or end-of-block decision appears as a pause, disable or reload pulse in the cycle after the wrong element, and that pulse then fixes the number of elements seen before the channel stops.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_HOLD = 2'd3
  } seq_state_t;

  localparam int DATA_W   = 32;
  localparam int EV_HALF  = 0;
  localparam int EV_LAST  = 1;
  localparam int EV_FRAME = 2;
  localparam int EV_PKT   = 3;
  localparam int EV_BLOCK = 4;
  localparam int EV_NUM   = 5;

  function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/dma2d_addr.sv
module dma2d_addr #(
  parameter int AW  = 32,
  parameter int EIW = 16,
  parameter int FIW = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic                  step,
  input  logic                  frame_end,
  input  logic [AW-1:0]         base,
  input  logic signed [EIW-1:0] eidx,
  input  logic signed [FIW-1:0] fidx,
  output logic [AW-1:0]         addr,
  output logic [AW-1:0]         addr_nx
);
  logic [AW-1:0] e_ext, f_ext;

  // sign-extend the strides to the address width
  assign e_ext   = AW'(eidx);
  assign f_ext   = AW'(fidx);
  assign addr_nx = addr + e_ext + (frame_end ? f_ext : '0);

  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= base;
    else if (step) addr <= addr_nx;
  end
endmodule

// File: rtl/dma2d_ctr.sv
module dma2d_ctr #(
  parameter int ECW = 24,
  parameter int FCW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic           pkt_on,
  input  logic [ECW-1:0] n_elem,
  input  logic [FCW-1:0] n_frame,
  input  logic [ECW-1:0] n_pkt,
  output logic           frame_end,
  output logic           block_end,
  output logic           half_hit,
  output logic           last_hit,
  output logic           pkt_end
);
  logic [ECW-1:0] elem, pkt, elem_nx, half_pt;
  logic [FCW-1:0] frame;

  assign elem_nx   = elem + ECW'(1);
  assign half_pt   = n_elem >> 1;
  assign frame_end = (elem_nx == n_elem);
  assign block_end = frame_end && (frame + FCW'(1) == n_frame);
  assign half_hit  = (half_pt != '0) && (elem_nx == half_pt);
  assign last_hit  = (elem == '0) && (frame == n_frame - FCW'(1));
  assign pkt_end   = pkt_on && (pkt + ECW'(1) == n_pkt);

  always_ff @(posedge clk) begin
    if (rst || load) begin
      elem  <= '0;
      frame <= '0;
      pkt   <= '0;
    end else if (step) begin
      elem  <= frame_end ? '0 : elem_nx;
      if (frame_end) frame <= frame + FCW'(1);
      if (pkt_on)    pkt   <= pkt_end ? '0 : pkt + ECW'(1);
    end
  end
endmodule

// File: rtl/dma2d_seq.sv
module dma2d_seq
  import dma2d_pkg::*;
#(
  parameter int AW  = 32,
  parameter int ECW = 24,
  parameter int FCW = 16,
  parameter int EIW = 16,
  parameter int FIW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [AW-1:0]     cfg_src_base,
  input  logic [AW-1:0]     cfg_dst_base,
  input  logic [EIW-1:0]    cfg_src_eidx,
  input  logic [EIW-1:0]    cfg_dst_eidx,
  input  logic [FIW-1:0]    cfg_src_fidx,
  input  logic [FIW-1:0]    cfg_dst_fidx,
  input  logic [ECW-1:0]    cfg_n_elem,
  input  logic [FCW-1:0]    cfg_n_frame,
  input  logic [ECW-1:0]    cfg_n_pkt,
  input  logic [1:0]        cfg_size,
  input  logic [DATA_W-1:0] cfg_color,
  input  logic              cfg_fill,
  input  logic              cfg_tcopy,
  input  logic              cfg_sync,
  input  logic              cfg_fsync,
  input  logic              cfg_bsync,
  input  logic              cfg_src_sync,
  input  logic              cfg_legacy,
  input  logic              cfg_link_en,
  input  logic              cfg_auto_init,
  input  logic              cfg_repeat,
  input  logic              cfg_end_prog,
  input  logic [EV_NUM-1:0] cfg_ien,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_req,
  output logic [AW-1:0]     rd_addr,
  output logic              wr_req,
  output logic [AW-1:0]     wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [EV_NUM-1:0] ev,
  output logic              deact,
  output logic              ch_disable,
  output logic              reload,
  output logic              link_req,
  output logic              wait_prog,
  output logic [15:0]       cur_pos
);
  localparam int NPORT = 2;

  seq_state_t st;
  logic load, step;
  logic frame_end, block_end, half_hit, last_hit, pkt_end;
  logic pkt_mode, elem_sync, frm_sync, pause;
  logic pol_dis, pol_link, pol_rel, pol_wait;
  logic [DATA_W-1:0] msk, key, rd_m;
  logic [NPORT-1:0][AW-1:0]  base_v, addr_v, addr_nx_v;
  logic [NPORT-1:0][EIW-1:0] eidx_v;
  logic [NPORT-1:0][FIW-1:0] fidx_v;

  assign base_v = {cfg_dst_base, cfg_src_base};
  assign eidx_v = {cfg_dst_eidx, cfg_src_eidx};
  assign fidx_v = {cfg_dst_fidx, cfg_src_fidx};

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      dma2d_addr #(.AW(AW), .EIW(EIW), .FIW(FIW)) u_addr (
        .clk(clk), .rst(rst), .load(load), .step(step),
        .frame_end(frame_end), .base(base_v[p]),
        .eidx(eidx_v[p]), .fidx(fidx_v[p]),
        .addr(addr_v[p]), .addr_nx(addr_nx_v[p])
      );
    end
  endgenerate

  dma2d_ctr #(.ECW(ECW), .FCW(FCW)) u_ctr (
    .clk(clk), .rst(rst), .load(load), .step(step), .pkt_on(pkt_mode),
    .n_elem(cfg_n_elem), .n_frame(cfg_n_frame), .n_pkt(cfg_n_pkt),
    .frame_end(frame_end), .block_end(block_end), .half_hit(half_hit),
    .last_hit(last_hit), .pkt_end(pkt_end)
  );

  assign rd_addr = addr_v[0];
  assign wr_addr = addr_v[1];

  always_comb begin
    msk       = size_mask(cfg_size);
    key       = cfg_color & msk;
    rd_m      = rd_data & msk;
    pkt_mode  = cfg_fsync && cfg_bsync;
    elem_sync = cfg_sync && !cfg_fsync && !cfg_bsync;
    frm_sync  = cfg_sync && cfg_fsync && !cfg_bsync;
    pause     = elem_sync || (frm_sync && frame_end) ||
                (pkt_mode && cfg_sync && pkt_end);
    pol_dis   = block_end && (cfg_legacy || !cfg_auto_init);
    pol_link  = block_end && cfg_legacy && cfg_link_en;
    pol_rel   = block_end && !cfg_legacy && cfg_auto_init &&
                (cfg_repeat || cfg_end_prog);
    pol_wait  = block_end && !cfg_legacy && cfg_auto_init &&
                !cfg_repeat && !cfg_end_prog;
    step      = (st == ST_WR);
    load      = (go && st == ST_IDLE) || (go && st == ST_HOLD && wait_prog) ||
                (step && pol_rel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      rd_req     <= 1'b0;
      wr_req     <= 1'b0;
      wr_data    <= '0;
      ev         <= '0;
      deact      <= 1'b0;
      ch_disable <= 1'b0;
      reload     <= 1'b0;
      link_req   <= 1'b0;
      wait_prog  <= 1'b0;
      cur_pos    <= '0;
    end else begin
      ev         <= '0;
      deact      <= 1'b0;
      ch_disable <= 1'b0;
      reload     <= 1'b0;
      link_req   <= 1'b0;
      case (st)
        ST_IDLE, ST_HOLD: begin
          if (go) begin
            wait_prog <= 1'b0;
            if (cfg_fill) begin
              st <= ST_WR; wr_req <= 1'b1; wr_data <= key;
            end else begin
              st <= ST_RD; rd_req <= 1'b1;
            end
          end
        end
        ST_RD: begin
          if (rd_valid) begin
            rd_req  <= 1'b0;
            wr_data <= rd_m;
            wr_req  <= !(cfg_tcopy && rd_m == key);
            st      <= ST_WR;
          end
        end
        default: begin
          wr_req <= 1'b0;
          ev     <= cfg_ien & {block_end, pkt_end && !cfg_src_sync,
                               frame_end, last_hit, half_hit};
          if (frame_end && !cfg_sync) cur_pos <= addr_nx_v[1][15:0];
          reload <= pol_rel;
          if (pol_dis) begin
            ch_disable <= 1'b1;
            link_req   <= pol_link;
            st         <= ST_IDLE;
          end else if (pause || pol_wait) begin
            deact     <= 1'b1;
            wait_prog <= pol_wait;
            st        <= ST_HOLD;
          end else if (cfg_fill) begin
            wr_req <= 1'b1; wr_data <= key;
          end else begin
            rd_req <= 1'b1; st <= ST_RD;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dma2d_seq_chk.sv
module dma2d_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_fill,
  input logic       cfg_legacy,
  input logic [4:0] cfg_ien,
  input logic       rd_req,
  input logic       wr_req,
  input logic [4:0] ev,
  input logic       deact,
  input logic       ch_disable,
  input logic       link_req,
  input logic       wait_prog
);
  AST_RW_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && wr_req)); // R11
  AST_FILL_NO_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_req) |-> !$past(cfg_fill)); // R2
  AST_EV_GATED: assert property (@(posedge clk) disable iff (rst)
    (ev != 5'd0) |-> ((ev & ~$past(cfg_ien)) == 5'd0)); // R5
  AST_LINK_LEGACY: assert property (@(posedge clk) disable iff (rst)
    link_req |-> (ch_disable && $past(cfg_legacy))); // R8
  AST_DIS_NOT_DEACT: assert property (@(posedge clk) disable iff (rst)
    !(ch_disable && deact)); // R9
  AST_WAIT_WITH_DEACT: assert property (@(posedge clk) disable iff (rst)
    $rose(wait_prog) |-> deact); // R9
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rd_req && !wr_req && ev == 5'd0)); // R10
endmodule

bind dma2d_seq dma2d_seq_chk u_chk (
  .clk(clk), .rst(rst), .cfg_fill(cfg_fill), .cfg_legacy(cfg_legacy),
  .cfg_ien(cfg_ien), .rd_req(rd_req), .wr_req(wr_req), .ev(ev),
  .deact(deact), .ch_disable(ch_disable), .link_req(link_req),
  .wait_prog(wait_prog)
);

// File: tb/test_dma2d_seq.sv
module test_dma2d_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 3;
  localparam int V_NE[NV]  = '{4, 3, 1};
  localparam int V_NF[NV]  = '{3, 2, 4};
  localparam int V_SEI[NV] = '{4, -2, 1};
  localparam int V_DEI[NV] = '{4, 2, -1};
  localparam int V_SFI[NV] = '{16, 0, -3};
  localparam int V_DFI[NV] = '{-8, 100, 7};
  localparam int V_SZ[NV]  = '{2, 1, 0};

  logic clk = 0, rst = 1, go = 0;
  logic [31:0] cfg_src_base, cfg_dst_base, cfg_src_fidx, cfg_dst_fidx, cfg_color;
  logic [15:0] cfg_src_eidx, cfg_dst_eidx, cfg_n_frame;
  logic [23:0] cfg_n_elem, cfg_n_pkt;
  logic [1:0]  cfg_size;
  logic cfg_fill, cfg_tcopy, cfg_sync, cfg_fsync, cfg_bsync, cfg_src_sync;
  logic cfg_legacy, cfg_link_en, cfg_auto_init, cfg_repeat, cfg_end_prog;
  logic [4:0]  cfg_ien;
  logic rd_valid = 0;
  logic [31:0] rd_data = 0;
  logic rd_req, wr_req, deact, ch_disable, reload, link_req, wait_prog;
  logic [31:0] rd_addr, wr_addr, wr_data;
  logic [4:0]  ev;
  logic [15:0] cur_pos;

  int nchk = 0, nerr = 0, cyc = 0;
  int r_rd, r_wr, r_dis, r_deact, r_rel, r_link;
  int evc[5];
  logic [31:0] ms, md, exp_dst, exp_dat;
  logic [15:0] exp_cpos;
  int me, mf;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma2d_seq i_dma2d_seq (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nerr++;
      $display("FAIL R10 watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[15:0]};
  endfunction

  function automatic logic [31:0] msk();
    return (cfg_size == 2'd0) ? 32'hFF : (cfg_size == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_init();
    ms = cfg_src_base; md = cfg_dst_base; me = 0; mf = 0;
  endtask

  task automatic model_step();
    me++;
    ms = ms + 32'($signed(cfg_src_eidx));
    md = md + 32'($signed(cfg_dst_eidx));
    if (me == int'(cfg_n_elem)) begin
      me = 0; mf++;
      ms = ms + cfg_src_fidx;
      md = md + cfg_dst_fidx;
      if (!cfg_sync) exp_cpos = md[15:0];
    end
  endtask

  task automatic cfg_clear();
    cfg_src_base = 32'h1000; cfg_dst_base = 32'h8000;
    cfg_src_eidx = 16'd4; cfg_dst_eidx = 16'd4; cfg_src_fidx = 0; cfg_dst_fidx = 0;
    cfg_n_elem = 24'd2; cfg_n_frame = 16'd1; cfg_n_pkt = 24'd1; cfg_size = 2'd2;
    cfg_color = 32'h1234_5678; cfg_fill = 0; cfg_tcopy = 0; cfg_sync = 0;
    cfg_fsync = 0; cfg_bsync = 0; cfg_src_sync = 0; cfg_legacy = 0; cfg_link_en = 0;
    cfg_auto_init = 0; cfg_repeat = 0; cfg_end_prog = 0; cfg_ien = 5'h1F;
  endtask

  task automatic do_reset();
    rst = 1; go = 0; rd_valid = 0;
    repeat (2) @(negedge clk);
    rst = 0; exp_cpos = 0;
  endtask

  task automatic run(input int maxc);
    r_rd = 0; r_wr = 0; r_dis = 0; r_deact = 0; r_rel = 0; r_link = 0;
    for (int k = 0; k < 5; k++) evc[k] = 0;
    @(negedge clk) go = 1;
    for (int c = 0; c < maxc; c++) begin
      @(negedge clk); go = 0;
      if (reload) begin r_rel++; model_init(); end
      for (int k = 0; k < 5; k++) if (ev[k]) evc[k]++;
      if (link_req) r_link++;
      if (rd_req) begin
        r_rd++;
        chk(rd_addr == ms, "R1 read address", rd_addr, ms);
        exp_dst = md; exp_dat = memf(rd_addr) & msk();
        model_step();
        rd_valid = 1; rd_data = memf(rd_addr);
      end else rd_valid = 0;
      if (wr_req) begin
        r_wr++;
        if (cfg_fill) begin
          chk(wr_addr == md, "R2 fill write address", wr_addr, md);
          chk(wr_data == (cfg_color & msk()), "R2 fill data", wr_data, cfg_color & msk());
          model_step();
        end else begin
          chk(wr_addr == exp_dst, "R1 write address", wr_addr, exp_dst);
          chk(wr_data == exp_dat, "R1 write data", wr_data, exp_dat);
        end
      end
      if (ch_disable) begin r_dis++; break; end
      if (deact) begin r_deact++; break; end
    end
    rd_valid = 0;
  endtask

  initial begin
    cfg_clear();
    do_reset();
    @(negedge clk);
    // R10 reset state
    chk(!rd_req && !wr_req, "R10 no request after reset", {rd_req, wr_req}, 0);
    chk(ev == 0 && !deact && !ch_disable && !reload, "R10 no pulse after reset", ev, 0);
    chk(cur_pos == 0 && !wait_prog, "R10 cur_pos/wait after reset", cur_pos, 0);

    // table of plain copies: R1, R4, R5, R9 (auto-init off), R11
    for (int v = 0; v < NV; v++) begin
      int hexp;
      cfg_clear();
      cfg_n_elem = 24'(V_NE[v]); cfg_n_frame = 16'(V_NF[v]);
      cfg_src_eidx = 16'(V_SEI[v]); cfg_dst_eidx = 16'(V_DEI[v]);
      cfg_src_fidx = 32'(V_SFI[v]); cfg_dst_fidx = 32'(V_DFI[v]);
      cfg_size = 2'(V_SZ[v]);
      do_reset(); model_init();
      run(200);
      hexp = (V_NE[v] >= 2) ? V_NF[v] : 0;
      chk(r_rd == V_NE[v]*V_NF[v], "R11 one read per element", r_rd, V_NE[v]*V_NF[v]);
      chk(r_wr == V_NE[v]*V_NF[v], "R1 write count", r_wr, V_NE[v]*V_NF[v]);
      chk(evc[2] == V_NF[v], "R5 frame events", evc[2], V_NF[v]);
      chk(evc[0] == hexp, "R5 half-frame events", evc[0], hexp);
      chk(evc[1] == 1 && evc[4] == 1, "R5 last-frame/block events", {evc[1], evc[4]}, 2'b11);
      chk(r_dis == 1 && r_deact == 0, "R9 auto-init off disables", r_dis, 1);
      chk(cur_pos == exp_cpos, "R4 cur_pos at frame end", cur_pos, exp_cpos);
    end

    // R2 fill, byte size
    cfg_clear(); cfg_fill = 1; cfg_size = 2'd0; cfg_n_elem = 3;
    do_reset(); model_init(); run(50);
    chk(r_rd == 0, "R2 no reads in fill", r_rd, 0);
    chk(r_wr == 3, "R2 fill writes", r_wr, 3);

    // R3 transparent copy: element at 0x1008 matches the key
    cfg_clear(); cfg_tcopy = 1; cfg_n_elem = 4; cfg_color = memf(32'h1008);
    do_reset(); model_init(); run(50);
    chk(r_rd == 4, "R3 reads still made", r_rd, 4);
    chk(r_wr == 3, "R3 matching write dropped", r_wr, 3);

    // R5 all events disabled
    cfg_clear(); cfg_ien = 0; cfg_n_frame = 2;
    do_reset(); model_init(); run(50);
    chk(evc[0]+evc[1]+evc[2]+evc[3]+evc[4] == 0, "R5 events gated off", evc[2], 0);

    // R7 element sync: 4 elements, three pauses then disable
    cfg_clear(); cfg_sync = 1; cfg_n_frame = 2;
    do_reset(); model_init();
    for (int i = 0; i < 3; i++) begin
      run(20);
      chk(r_deact == 1 && r_rd == 1, "R7 element sync pause", r_rd, 1);
    end
    run(20);
    chk(r_dis == 1, "R7 element sync final disable", r_dis, 1);
    chk(cur_pos == 0, "R4 synced channel leaves cur_pos", cur_pos, 0);

    // R7 frame sync
    cfg_clear(); cfg_sync = 1; cfg_fsync = 1; cfg_n_elem = 3; cfg_n_frame = 2;
    do_reset(); model_init();
    run(50);
    chk(r_deact == 1 && r_rd == 3, "R7 frame sync pause", r_rd, 3);
    run(50);
    chk(r_dis == 1 && r_rd == 3, "R7 frame sync resume to end", r_rd, 3);

    // R6 packet mode, then source-synchronised variant
    for (int s = 0; s < 2; s++) begin
      int pk;
      cfg_clear(); cfg_sync = 1; cfg_fsync = 1; cfg_bsync = 1; cfg_src_sync = s[0];
      cfg_n_elem = 4; cfg_n_frame = 2; cfg_n_pkt = 3;
      do_reset(); model_init();
      run(50); pk = evc[3];
      chk(r_deact == 1 && r_rd == 3, "R6 pause at packet end", r_rd, 3);
      run(50); pk += evc[3];
      chk(r_deact == 1 && r_rd == 3, "R6 second packet", r_rd, 3);
      run(50); pk += evc[3];
      chk(r_dis == 1 && r_rd == 2, "R6 block end after packets", r_rd, 2);
      chk(pk == (s ? 0 : 2), "R6 packet events", pk, s ? 0 : 2);
    end

    // R8 legacy with link
    cfg_clear(); cfg_legacy = 1; cfg_link_en = 1; cfg_auto_init = 1; cfg_repeat = 1;
    do_reset(); model_init(); run(50);
    chk(r_dis == 1 && r_link == 1 && r_rel == 0, "R8 legacy disable and link", r_link, 1);

    // R9 repeat reload: addresses restart (checked by model)
    cfg_clear(); cfg_auto_init = 1; cfg_repeat = 1;
    do_reset(); model_init(); run(30);
    chk(r_rel >= 2 && r_dis == 0, "R9 repeat reloads", r_rel, 2);

    // R9 wait for reprogramming
    cfg_clear(); cfg_auto_init = 1;
    do_reset(); model_init(); run(50);
    chk(r_deact == 1 && r_dis == 0, "R9 wait pause", r_deact, 1);
    chk(wait_prog == 1, "R9 wait flag set", wait_prog, 1);
    model_init(); run(50);
    chk(r_rd == 2 && r_deact == 1, "R9 go reloads after wait", r_rd, 2);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule